// File: doc/BRIEF.md
# Dispatch Group Slot Checker

This block keeps track of how full a five-slot instruction dispatch group is. It decides, for one pre-decoded candidate instruction at a time, whether that instruction may join the group that is being formed. Each candidate comes with a unit class and a set of attribute flags: first-only, single, cracked, counter-write and branch-through-counter. A debug marker flag also comes with it. The verdict is combinational. It is either clear, hazard (the candidate must wait for a new group) or insert-no-op (joining would cause a costly structural conflict).

An issue strobe commits the candidate to the group. The commit advances the slot count according to the instruction class. A commit that fills the group ends it. An empty-cycle strobe uses up one slot without an instruction. When a group ends, the slot count and the counter-write flag both clear. A synchronous reset starts an empty group.

Top module: `dgroup_slot_check`

## Requirements
- R1: After synchronous reset the slot count is 0 and the counter-armed flag is 0. With no hazard condition present the verdict is clear. Verdict encoding: 0 clear, 1 hazard, 2 insert-no-op.
- R2: A candidate marked as debug, or with unit code 0 (pseudo), always gets verdict 0. Issuing it changes neither the slot count nor the counter-armed flag.
- R3: A candidate flagged first-only or single gets verdict 1 whenever the slot count is not 0.
- R4: A cracked candidate gets verdict 1 when the slot count is above 2. Issuing a cracked instruction adds two slots.
- R5: A candidate of unit code 1 to 5 (fixed-point, load/store, floating-point, vector ALU, vector permute) gets verdict 1 when the slot count is 4.
- R6: A candidate of unit code 6 (condition-register) gets verdict 1 when the slot count is 2 or more.
- R7: A candidate of unit code 7 (branch) is never given a slot hazard. Issuing a branch or a single instruction ends the group: the count becomes 0 and the counter-armed flag clears.
- R8: Issuing a non-ignored candidate with the counter-write flag arms the counter flag for the rest of the group. A branch-through-counter candidate gets verdict 2 while the flag is armed, unless a rule in R3 to R6 already gives verdict 1.
- R9: Issuing a non-ignored, non-cracked, non-closing instruction adds one slot. Reaching five slots ends the group, which clears the count and the counter-armed flag.
- R10: An empty-cycle strobe adds one slot, and reaching five ends the group as in R9. An empty-cycle strobe in the same cycle as an issue strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_unit | input | 3 | Candidate unit class code |
| in_first | input | 1 | Candidate must open a group |
| in_single | input | 1 | Candidate occupies a whole group |
| in_cracked | input | 1 | Candidate splits into two slots |
| in_ctr_wr | input | 1 | Candidate writes the counter register |
| in_ctr_br | input | 1 | Candidate branches through the counter register |
| in_debug | input | 1 | Candidate is a debug marker |
| issue | input | 1 | Commit the candidate to the group |
| empty_cycle | input | 1 | Consume one slot with no instruction |
| verdict | output | 2 | 0 clear, 1 hazard, 2 insert-no-op |
| slots_used | output | 3 | Slots used in the current group |
| ctr_armed | output | 1 | A counter write was issued in this group |

## Verification
The bench builds the block with its default parameters: five slots, a condition-register limit of two and a cracked limit of two. With these values every reachable group state is small. Each slot count from 0 to 4, with the counter flag clear or armed, is reached from reset by an optional counter-write issue followed by empty cycles. In every such state, all eight unit codes are crossed with all 64 combinations of the six flag bits. The verdict and the state after issue are compared with an arithmetic model. Directed sequences then cover the wrap at five empty cycles and the precedence of issue over empty-cycle.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

  typedef enum logic [2:0] {
    U_PSEUDO = 3'd0,
    U_FIX    = 3'd1,
    U_LDST   = 3'd2,
    U_FLT    = 3'd3,
    U_VALU   = 3'd4,
    U_VPERM  = 3'd5,
    U_CREG   = 3'd6,
    U_BRANCH = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    V_CLEAR  = 2'd0,
    V_HAZARD = 2'd1,
    V_NOOP   = 2'd2
  } verdict_e;

  function automatic logic is_compute(input unit_e u);
    return (u == U_FIX) || (u == U_LDST) || (u == U_FLT) ||
           (u == U_VALU) || (u == U_VPERM);
  endfunction

  // Slot count after one commit, before the group-end check.
  function automatic int unsigned commit_count(input int unsigned used,
                                               input int unsigned nb_limit,
                                               input logic closes,
                                               input logic cracked);
    int unsigned n;
    n = closes ? nb_limit : used;
    n = n + 1 + (cracked ? 1 : 0);
    return n;
  endfunction

endpackage

// File: rtl/dgs_verdict.sv
module dgs_verdict
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_LIMIT    = 2,
  parameter int CRACK_LIMIT = 2,
  parameter int CNT_W       = 3
) (
  input  logic [CNT_W-1:0] used,
  input  logic             armed,
  input  logic [2:0]       unit_code,
  input  logic             first_only,
  input  logic             single,
  input  logic             cracked,
  input  logic             ctr_br,
  input  logic             debug,
  output logic [1:0]       verdict,
  output logic             ignored,
  output logic             slot_hazard
);
  localparam int NB_LIMIT = GROUP_SLOTS - 1;

  unit_e u;
  logic  open_hz, crack_hz, compute_hz, creg_hz;

  assign u       = unit_e'(unit_code);
  assign ignored = debug || (u == U_PSEUDO);

  always_comb begin
    open_hz    = (first_only || single) && (int'(used) != 0);
    crack_hz   = cracked && (int'(used) > CRACK_LIMIT);
    compute_hz = is_compute(u) && (int'(used) == NB_LIMIT);
    creg_hz    = (u == U_CREG) && (int'(used) >= CR_LIMIT);
    slot_hazard = !ignored && (open_hz || crack_hz || compute_hz || creg_hz);
  end

  always_comb begin
    if (ignored)                 verdict = V_CLEAR;
    else if (slot_hazard)        verdict = V_HAZARD;
    else if (armed && ctr_br)    verdict = V_NOOP;
    else                         verdict = V_CLEAR;
  end
endmodule

// File: rtl/dgs_slot_track.sv
module dgs_slot_track
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_issue,
  input  logic             do_empty,
  input  logic             closes,
  input  logic             cracked,
  input  logic             ctr_wr,
  output logic [CNT_W-1:0] used,
  output logic             armed,
  output logic             group_end
);
  localparam int NB_LIMIT = GROUP_SLOTS - 1;

  int unsigned next_cnt;
  logic        next_armed;

  always_comb begin
    next_cnt   = int'(used);
    next_armed = armed;
    if (do_issue) begin
      next_cnt   = commit_count(int'(used), NB_LIMIT, closes, cracked);
      next_armed = armed || ctr_wr;
    end else if (do_empty) begin
      next_cnt   = int'(used) + 1;
    end
    group_end = (do_issue || do_empty) && (next_cnt >= GROUP_SLOTS);
  end

  always_ff @(posedge clk) begin
    if (rst || group_end) begin
      used  <= '0;
      armed <= 1'b0;
    end else begin
      used  <= CNT_W'(next_cnt);
      armed <= next_armed;
    end
  end
endmodule

// File: rtl/dgroup_slot_check.sv
module dgroup_slot_check
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_LIMIT    = 2,
  parameter int CRACK_LIMIT = 2,
  localparam int CNT_W      = $clog2(GROUP_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       in_unit,
  input  logic             in_first,
  input  logic             in_single,
  input  logic             in_cracked,
  input  logic             in_ctr_wr,
  input  logic             in_ctr_br,
  input  logic             in_debug,
  input  logic             issue,
  input  logic             empty_cycle,
  output logic [1:0]       verdict,
  output logic [CNT_W-1:0] slots_used,
  output logic             ctr_armed
);
  logic ignored, slot_hazard, group_end;
  logic do_issue, do_empty, closes;

  assign do_issue = issue && !ignored;
  assign do_empty = empty_cycle && !issue;
  assign closes   = (unit_e'(in_unit) == U_BRANCH) || in_single;

  dgs_verdict #(
    .GROUP_SLOTS(GROUP_SLOTS), .CR_LIMIT(CR_LIMIT),
    .CRACK_LIMIT(CRACK_LIMIT), .CNT_W(CNT_W)
  ) u_verdict (
    .used(slots_used), .armed(ctr_armed), .unit_code(in_unit),
    .first_only(in_first), .single(in_single), .cracked(in_cracked),
    .ctr_br(in_ctr_br), .debug(in_debug), .verdict(verdict),
    .ignored(ignored), .slot_hazard(slot_hazard)
  );

  dgs_slot_track #(
    .GROUP_SLOTS(GROUP_SLOTS), .CNT_W(CNT_W)
  ) u_track (
    .clk(clk), .rst(rst), .do_issue(do_issue), .do_empty(do_empty),
    .closes(closes), .cracked(in_cracked), .ctr_wr(in_ctr_wr),
    .used(slots_used), .armed(ctr_armed), .group_end(group_end)
  );
endmodule

// File: rtl/dgs_checker.sv
module dgs_checker #(
  parameter int GROUP_SLOTS = 5,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             issue,
  input logic             empty_cycle,
  input logic             in_ctr_br,
  input logic [1:0]       verdict,
  input logic [CNT_W-1:0] slots_used,
  input logic             ctr_armed,
  input logic             ignored,
  input logic             slot_hazard,
  input logic             group_end
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (slots_used == '0) && !ctr_armed);

  // R9
  group_end_clears_chk: assert property (@(posedge clk) disable iff (rst)
    group_end |=> (slots_used == '0) && !ctr_armed);

  // R2
  ignored_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && ignored) |=> $stable(slots_used) && $stable(ctr_armed));

  // R8
  ctr_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctr_armed && in_ctr_br && !ignored && !slot_hazard) |-> verdict == 2'd2);

  // R10
  empty_step_chk: assert property (@(posedge clk) disable iff (rst)
    (empty_cycle && !issue && int'(slots_used) < GROUP_SLOTS - 1)
      |=> int'(slots_used) == int'($past(slots_used)) + 1);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(slots_used) < GROUP_SLOTS);
endmodule

bind dgroup_slot_check dgs_checker #(
  .GROUP_SLOTS(GROUP_SLOTS), .CNT_W(CNT_W)
) u_dgs_checker (
  .clk(clk), .rst(rst), .issue(issue), .empty_cycle(empty_cycle),
  .in_ctr_br(in_ctr_br), .verdict(verdict), .slots_used(slots_used),
  .ctr_armed(ctr_armed), .ignored(ignored), .slot_hazard(slot_hazard),
  .group_end(group_end)
);

// File: tb/test_dgroup_slot_check.sv
module test_dgroup_slot_check;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] in_unit;
  logic       in_first, in_single, in_cracked, in_ctr_wr, in_ctr_br, in_debug;
  logic       issue, empty_cycle;
  logic [1:0] verdict;
  logic [2:0] slots_used;
  logic       ctr_armed;

  int checks   = 0;
  int failures = 0;
  logic done   = 1'b0;

  always #5 clk = ~clk;

  dgroup_slot_check i_dgroup_slot_check (
    .clk(clk), .rst(rst), .in_unit(in_unit), .in_first(in_first),
    .in_single(in_single), .in_cracked(in_cracked), .in_ctr_wr(in_ctr_wr),
    .in_ctr_br(in_ctr_br), .in_debug(in_debug), .issue(issue),
    .empty_cycle(empty_cycle), .verdict(verdict), .slots_used(slots_used),
    .ctr_armed(ctr_armed)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_unit = 3'd0; in_first = 0; in_single = 0; in_cracked = 0;
    in_ctr_wr = 0; in_ctr_br = 0; in_debug = 0; issue = 0; empty_cycle = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  // Reference verdict by rule order of R2..R8.
  function automatic int ref_verdict(input int cnt, input int armed, input int u,
                                     input int f, input int s, input int c,
                                     input int cb, input int dbg,
                                     output string tag);
    if (dbg != 0 || u == 0) begin tag = "R2"; return 0; end
    if ((f | s) != 0 && cnt > 0) begin tag = "R3"; return 1; end
    if (c != 0 && cnt >= 3) begin tag = "R4"; return 1; end
    if (u >= 1 && u <= 5 && cnt == 4) begin tag = "R5"; return 1; end
    if (u == 6 && cnt >= 2) begin tag = "R6"; return 1; end
    if (armed != 0 && cb != 0) begin tag = "R8"; return 2; end
    tag = (u == 7) ? "R7" : "R9";
    return 0;
  endfunction

  // Model: bring the block to count cnt with flag armed.
  task automatic reach(input int cnt, input int armed);
    do_reset();
    if (armed != 0) begin
      in_unit = 3'd1; in_ctr_wr = 1; issue = 1;
      step();
    end
    for (int k = armed; k < cnt; k++) begin
      empty_cycle = 1;
      step();
    end
  endtask

  initial begin
    rst = 1'b0;
    idle();
    do_reset();
    // R1
    check("R1 count", int'(slots_used), 0);
    check("R1 armed", int'(ctr_armed), 0);
    check("R1 verdict", int'(verdict), 0);

    for (int cnt = 0; cnt < 5; cnt++) begin
      for (int armed = 0; armed < 2; armed++) begin
        if (armed == 1 && cnt == 0) continue;
        for (int u = 0; u < 8; u++) begin
          for (int b = 0; b < 64; b++) begin
            int f, s, c, cw, cb, dbg, ev, n, na, ign;
            string tag, ntag;
            f = b & 1; s = (b >> 1) & 1; c = (b >> 2) & 1;
            cw = (b >> 3) & 1; cb = (b >> 4) & 1; dbg = (b >> 5) & 1;
            reach(cnt, armed);
            in_unit = 3'(u); in_first = f[0]; in_single = s[0];
            in_cracked = c[0]; in_ctr_wr = cw[0]; in_ctr_br = cb[0];
            in_debug = dbg[0]; issue = 1;
            #1;
            ev = ref_verdict(cnt, armed, u, f, s, c, cb, dbg, tag);
            check({tag, " verdict"}, int'(verdict), ev);
            ign = (dbg != 0 || u == 0) ? 1 : 0;
            if (ign != 0) begin
              n = cnt; na = armed; ntag = "R2";
            end else begin
              if (u == 7 || s != 0) begin n = 5; ntag = "R7"; end
              else begin n = cnt + 1; ntag = "R9"; end
              if (c != 0) begin n = n + 1; ntag = "R4"; end
              na = (armed != 0 || cw != 0) ? 1 : 0;
              if (n >= 5) begin n = 0; na = 0; end
              else if (cw != 0) ntag = "R8";
            end
            step();
            check({ntag, " count"}, int'(slots_used), n);
            check({ntag, " armed"}, int'(ctr_armed), na);
          end
        end
      end
    end

    // R10: five empty cycles wrap the group
    do_reset();
    for (int k = 1; k <= 5; k++) begin
      empty_cycle = 1;
      step();
      check("R10 empty wrap", int'(slots_used), k % 5);
    end

    // R10: issue wins over a simultaneous empty-cycle strobe
    reach(2, 0);
    in_unit = 3'd1; issue = 1; empty_cycle = 1;
    step();
    check("R10 issue priority", int'(slots_used), 3);

    // R10: pseudo issue still blocks the empty-cycle strobe
    in_unit = 3'd0; issue = 1; empty_cycle = 1;
    step();
    check("R10 pseudo issue blocks empty", int'(slots_used), 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule